// File: doc/BRIEF.md
# Two-Port Mailbox Window Bank

The block is an inter-processor mailbox. A sending agent and a receiving agent each reach it through their own simple register port: a write strobe, a byte address, write data and a combinational read-data bus. The bank holds a configurable number of 32-bit channel windows. Each window owns one status word that both sides share. The sender raises bits by writing ones. The receiver reads the raw word or the unmasked part of it, and drops bits by writing ones. A per-window mask decides which bits may interrupt the receiver.

Three interrupt outputs are produced. The receive interrupt stays high while any window holds a set bit that is not masked. A summary form of it is gated by a frame-level enable. The sender side has a per-window completion flag that is raised when a window's status word falls to zero. It is cleared by software and gated by a per-window enable and a frame-level enable. Each side can also read a packed word list with one bit per window. The sender has a request/ready handshake register pair, and both sides can read the implemented window count.

Top module: `mbx_bank`

## Requirements
- R1: The read-only configuration word at byte offset 0xF80 returns the window count parameter (1 to 124) in bits 6:0 and zeros above, on both ports.
- R2: Window w occupies bytes 32*w to 32*w+31. A sender write to the window's set register (offset 0x0C) ORs the written bits into the shared status word, and the sender reads that word at offset 0x00.
- R3: A receiver write to the window's clear register (offset 0x08) clears the status bits written as one. The receiver reads the same status word at offset 0x00.
- R4: The receiver mask (offset 0x10) gains bits through mask-set (0x14) and loses them through mask-clear (0x18). The masked status at 0x04 reads as status AND NOT mask.
- R5: After reset every mask reads 0xFFFFFFFF, and every other register reads zero.
- R6: rx_irq is high exactly while some window has a nonzero masked status.
- R7: The sender completion flag of a window (offset 0x10, bit 0) becomes 1 in the cycle its status word goes from nonzero to zero. Writing 1 to bit 0 of offset 0x14 clears it, and a completion in the same cycle as that clear leaves it set.
- R8: Bit 2 of the frame enable register (0xF98, bits 2:0 readable) gates the summary outputs. tx_done_irq is high when that sender bit is 1 and some window has both its completion flag and its enable (offset 0x18, bit 0) set. rx_summary_irq is high when the receiver's bit 2 is 1 and rx_irq is high.
- R9: Four combined words at 0xFA0, 0xFA4, 0xFA8 and 0xFAC hold window n at bit n mod 32 of word n/32. On the sender this bit is completion flag AND enable, and on the receiver it is nonzero masked status. Bits for windows that are not implemented read zero.
- R10: When a sender set and a receiver clear hit the same status bit in the same cycle, the bit ends up set (default SET_WINS=1). Clears of other bits still apply.
- R11: Writing 1 to bit 0 of the sender access-request register (0xF88) makes access-ready (0xF8C) read 1, and writing 0 makes it read 0.
- R12: Reads of reserved or write-only offsets, including windows at or above the window count, return zero. Writes there change no readable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_we | input | 1 | Sender write strobe |
| s_addr | input | 12 | Sender byte address |
| s_wdata | input | 32 | Sender write data |
| s_rdata | output | 32 | Sender read data (combinational) |
| r_we | input | 1 | Receiver write strobe |
| r_addr | input | 12 | Receiver byte address |
| r_wdata | input | 32 | Receiver write data |
| r_rdata | output | 32 | Receiver read data (combinational) |
| rx_irq | output | 1 | Any unmasked status bit pending |
| rx_summary_irq | output | 1 | rx_irq gated by the receiver frame enable |
| tx_done_irq | output | 1 | Sender completion interrupt |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a sender set and a receiver clear on one status word. The second pair is the receiver's final clear that drains a window and a sender write that clears that window's completion flag. The bench drives both ports on the same clock edge for each pair. It then reads the status word back and checks that the set bit survived while the clear of another bit still applied. It also reads the completion flag and checks that the new completion won over the clear.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int WORD_W    = 32;
   localparam int ADDR_W    = 12;
   localparam int MAX_WIN   = 124;
   localparam int COMB_REGS = 4;
   localparam int SLOT_B    = 32;

   // per-window offsets, sender view
   localparam logic [4:0] S_STAT = 5'h00;
   localparam logic [4:0] S_SET  = 5'h0C;
   localparam logic [4:0] S_IST  = 5'h10;
   localparam logic [4:0] S_ICLR = 5'h14;
   localparam logic [4:0] S_IEN  = 5'h18;

   // per-window offsets, receiver view
   localparam logic [4:0] R_STAT = 5'h00;
   localparam logic [4:0] R_MSKD = 5'h04;
   localparam logic [4:0] R_CLR  = 5'h08;
   localparam logic [4:0] R_MASK = 5'h10;
   localparam logic [4:0] R_MSET = 5'h14;
   localparam logic [4:0] R_MCLR = 5'h18;

   // frame registers
   localparam logic [ADDR_W-1:0] F_CFG  = 12'hF80;
   localparam logic [ADDR_W-1:0] F_AREQ = 12'hF88;
   localparam logic [ADDR_W-1:0] F_ARDY = 12'hF8C;
   localparam logic [ADDR_W-1:0] F_IEN  = 12'hF98;
   localparam logic [ADDR_W-1:0] F_CMB0 = 12'hFA0;

   // frame enable: bit2 combined, bit1 toward-ready, bit0 toward-not-ready
   typedef struct packed {
      logic comb_en;
      logic up_en;
      logic down_en;
   } fen_t;
endpackage

// File: rtl/mbx_window.sv
module mbx_window
   import mbx_pkg::*;
#(
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic              clr_we,
   input  logic              mset_we,
   input  logic              mclr_we,
   input  logic              iclr_we,
   input  logic              ien_we,
   input  logic [WORD_W-1:0] s_wdata,
   input  logic [WORD_W-1:0] r_wdata,
   output logic [WORD_W-1:0] stat,
   output logic [WORD_W-1:0] mask,
   output logic [WORD_W-1:0] masked,
   output logic              ist,
   output logic              ien
);
   logic [WORD_W-1:0] set_bits, clr_bits, stat_nxt;
   logic              drained;

   assign set_bits = set_we ? s_wdata : '0;
   assign clr_bits = clr_we ? r_wdata : '0;

   generate
      if (SET_WINS) begin : g_set_first
         assign stat_nxt = (stat & ~clr_bits) | set_bits;
      end else begin : g_clr_first
         assign stat_nxt = (stat | set_bits) & ~clr_bits;
      end
   endgenerate

   assign drained = (stat != '0) && (stat_nxt == '0);
   assign masked  = stat & ~mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         mask <= '1;
         ist  <= 1'b0;
         ien  <= 1'b0;
      end else begin
         stat <= stat_nxt;
         if (mset_we || mclr_we)
            mask <= (mask & ~(mclr_we ? r_wdata : '0)) | (mset_we ? r_wdata : '0);
         if (drained)
            ist <= 1'b1;
         else if (iclr_we && s_wdata[0])
            ist <= 1'b0;
         if (ien_we)
            ien <= s_wdata[0];
      end
   end
endmodule

// File: rtl/mbx_combine.sv
module mbx_combine
   import mbx_pkg::*;
#(
   parameter int NUM_WIN = 40
) (
   input  logic [NUM_WIN-1:0]                   flags,
   output logic [COMB_REGS-1:0][WORD_W-1:0]     words,
   output logic                                 any
);
   localparam int TOTAL = COMB_REGS * WORD_W;

   generate
      for (genvar i = 0; i < TOTAL; i++) begin : g_bit
         if (i < NUM_WIN) begin : g_live
            assign words[i / WORD_W][i % WORD_W] = flags[i];
         end else begin : g_dead
            assign words[i / WORD_W][i % WORD_W] = 1'b0;
         end
      end
   endgenerate

   assign any = |flags;
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
   import mbx_pkg::*;
#(
   parameter int NUM_WIN  = 40,
   parameter bit SET_WINS = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        s_we,
   input  logic [11:0] s_addr,
   input  logic [31:0] s_wdata,
   output logic [31:0] s_rdata,
   input  logic        r_we,
   input  logic [11:0] r_addr,
   input  logic [31:0] r_wdata,
   output logic [31:0] r_rdata,
   output logic        rx_irq,
   output logic        rx_summary_irq,
   output logic        tx_done_irq
);
   localparam int SEL_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
   localparam int WIN_END = NUM_WIN * SLOT_B;

   generate
      if (NUM_WIN < 1 || NUM_WIN > MAX_WIN) begin : g_bad_count
         $error("mbx_bank: NUM_WIN must lie in 1..124");
      end
   endgenerate

   logic [NUM_WIN-1:0][WORD_W-1:0] win_stat, win_mask, win_mskd;
   logic [NUM_WIN-1:0]             tx_ist, tx_ien, tx_flags, rx_flags;
   logic [COMB_REGS-1:0][WORD_W-1:0] tx_words, rx_words;
   logic                           tx_any, rx_any;
   logic                           acc_req;
   fen_t                           s_fen, r_fen;

   logic [6:0]       s_idx, r_idx;
   logic [4:0]       s_off, r_off;
   logic             s_in_win, r_in_win;
   logic [SEL_W-1:0] s_sel, r_sel;

   assign s_idx    = s_addr[11:5];
   assign r_idx    = r_addr[11:5];
   assign s_off    = s_addr[4:0];
   assign r_off    = r_addr[4:0];
   assign s_in_win = 32'(s_addr) < WIN_END;
   assign r_in_win = 32'(r_addr) < WIN_END;
   assign s_sel    = SEL_W'(s_idx);
   assign r_sel    = SEL_W'(r_idx);

   generate
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
         logic s_hit, r_hit;
         assign s_hit = s_we && s_in_win && (s_idx == 7'(w));
         assign r_hit = r_we && r_in_win && (r_idx == 7'(w));

         mbx_window #(.SET_WINS(SET_WINS)) u_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_we  (s_hit && s_off == S_SET),
            .clr_we  (r_hit && r_off == R_CLR),
            .mset_we (r_hit && r_off == R_MSET),
            .mclr_we (r_hit && r_off == R_MCLR),
            .iclr_we (s_hit && s_off == S_ICLR),
            .ien_we  (s_hit && s_off == S_IEN),
            .s_wdata (s_wdata),
            .r_wdata (r_wdata),
            .stat    (win_stat[w]),
            .mask    (win_mask[w]),
            .masked  (win_mskd[w]),
            .ist     (tx_ist[w]),
            .ien     (tx_ien[w])
         );

         assign tx_flags[w] = tx_ist[w] & tx_ien[w];
         assign rx_flags[w] = |win_mskd[w];
      end
   endgenerate

   mbx_combine #(.NUM_WIN(NUM_WIN)) u_tx_comb (
      .flags (tx_flags),
      .words (tx_words),
      .any   (tx_any)
   );

   mbx_combine #(.NUM_WIN(NUM_WIN)) u_rx_comb (
      .flags (rx_flags),
      .words (rx_words),
      .any   (rx_any)
   );

   assign rx_irq         = rx_any;
   assign rx_summary_irq = rx_any & r_fen.comb_en;
   assign tx_done_irq    = tx_any & s_fen.comb_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_req <= 1'b0;
         s_fen   <= '0;
         r_fen   <= '0;
      end else begin
         if (s_we && s_addr == F_AREQ)
            acc_req <= s_wdata[0];
         if (s_we && s_addr == F_IEN)
            s_fen <= fen_t'(s_wdata[2:0]);
         if (r_we && r_addr == F_IEN)
            r_fen <= fen_t'(r_wdata[2:0]);
      end
   end

   logic [WORD_W-1:0] cfg_word;
   assign cfg_word = {25'b0, 7'(NUM_WIN)};

   always_comb begin
      s_rdata = '0;
      if (s_in_win) begin
         case (s_off)
            S_STAT:  s_rdata = win_stat[s_sel];
            S_IST:   s_rdata = {31'b0, tx_ist[s_sel]};
            S_IEN:   s_rdata = {31'b0, tx_ien[s_sel]};
            default: s_rdata = '0;
         endcase
      end else begin
         case (s_addr)
            F_CFG:           s_rdata = cfg_word;
            F_AREQ, F_ARDY:  s_rdata = {31'b0, acc_req};
            F_IEN:           s_rdata = {29'b0, s_fen};
            F_CMB0:          s_rdata = tx_words[0];
            F_CMB0 + 12'h4:  s_rdata = tx_words[1];
            F_CMB0 + 12'h8:  s_rdata = tx_words[2];
            F_CMB0 + 12'hC:  s_rdata = tx_words[3];
            default:         s_rdata = '0;
         endcase
      end
   end

   always_comb begin
      r_rdata = '0;
      if (r_in_win) begin
         case (r_off)
            R_STAT:  r_rdata = win_stat[r_sel];
            R_MSKD:  r_rdata = win_mskd[r_sel];
            R_MASK:  r_rdata = win_mask[r_sel];
            default: r_rdata = '0;
         endcase
      end else begin
         case (r_addr)
            F_CFG:           r_rdata = cfg_word;
            F_IEN:           r_rdata = {29'b0, r_fen};
            F_CMB0:          r_rdata = rx_words[0];
            F_CMB0 + 12'h4:  r_rdata = rx_words[1];
            F_CMB0 + 12'h8:  r_rdata = rx_words[2];
            F_CMB0 + 12'hC:  r_rdata = rx_words[3];
            default:         r_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk #(
   parameter int NUM_WIN = 40
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_WIN-1:0][31:0] win_stat,
   input logic [NUM_WIN-1:0][31:0] win_mask,
   input logic [NUM_WIN-1:0]       tx_ist,
   input logic                     s_comb_en,
   input logic                     r_comb_en,
   input logic                     rx_irq,
   input logic                     rx_summary_irq,
   input logic                     tx_done_irq
);
   logic exp_rx;
   always_comb begin
      exp_rx = 1'b0;
      for (int w = 0; w < NUM_WIN; w++)
         exp_rx = exp_rx | (|(win_stat[w] & ~win_mask[w]));
   end

   // R6: receive interrupt follows the unmasked pending bits
   a_r6_rx_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq == exp_rx);

   // R5: first cycle out of reset, every mask is full and every status empty
   a_r5_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ((&win_mask) && (win_stat == '0)));

   // R8: summary outputs stay low while their frame enable is off
   a_r8_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !s_comb_en |-> !tx_done_irq);
   a_r8_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !r_comb_en |-> !rx_summary_irq);

   // R7: a drained window always carries its completion flag
   generate
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_drain
         a_r7_drain_flags: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(win_stat[w]) != 32'h0 && win_stat[w] == 32'h0) |-> tx_ist[w]);
      end
   endgenerate
endmodule

bind mbx_bank mbx_bank_chk #(.NUM_WIN(NUM_WIN)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .win_stat       (win_stat),
   .win_mask       (win_mask),
   .tx_ist         (tx_ist),
   .s_comb_en      (s_fen.comb_en),
   .r_comb_en      (r_fen.comb_en),
   .rx_irq         (rx_irq),
   .rx_summary_irq (rx_summary_irq),
   .tx_done_irq    (tx_done_irq)
);

// File: tb/mbx_bank_test.sv
`timescale 1ns/1ps
module mbx_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_we = 1'b0, r_we = 1'b0;
   logic [11:0] s_addr = '0, r_addr = '0;
   logic [31:0] s_wdata = '0, r_wdata = '0;
   logic [31:0] s_rdata, r_rdata;
   logic        rx_irq, rx_summary_irq, tx_done_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mbx_bank #(.NUM_WIN(40)) uut (
      .clk(clk), .rst_n(rst_n),
      .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
      .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
      .rx_irq(rx_irq), .rx_summary_irq(rx_summary_irq), .tx_done_irq(tx_done_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic s_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); s_we = 1'b1; s_addr = a; s_wdata = d;
      @(negedge clk); s_we = 1'b0;
   endtask

   task automatic r_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); r_we = 1'b1; r_addr = a; r_wdata = d;
      @(negedge clk); r_we = 1'b0;
   endtask

   task automatic both_wr(input logic [11:0] sa, input logic [31:0] sd,
                          input logic [11:0] ra, input logic [31:0] rd);
      @(negedge clk);
      s_we = 1'b1; s_addr = sa; s_wdata = sd;
      r_we = 1'b1; r_addr = ra; r_wdata = rd;
      @(negedge clk); s_we = 1'b0; r_we = 1'b0;
   endtask

   task automatic s_rd(input logic [11:0] a, output logic [31:0] d);
      s_addr = a; #1; d = s_rdata;
   endtask

   task automatic r_rd(input logic [11:0] a, output logic [31:0] d);
      r_addr = a; #1; d = r_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      r_rd(12'h010, v); check("R5 mask reset", v, 32'hFFFF_FFFF);
      s_rd(12'h000, v); check("R5 status reset", v, 32'h0);
      s_rd(12'hF8C, v); check("R5 ready reset", v, 32'h0);
      check("R5 irq reset", {29'b0, rx_irq, rx_summary_irq, tx_done_irq}, 32'h0);
      s_rd(12'hF80, v); check("R1 sender cfg", v, 32'd40);
      r_rd(12'hF80, v); check("R1 receiver cfg", v, 32'd40);
   endtask

   task automatic t_set_clear();
      logic [31:0] v;
      s_wr(12'h02C, 32'h0000_00F0);
      s_wr(12'h02C, 32'h0000_000F);
      s_rd(12'h020, v); check("R2 set ORs", v, 32'h0000_00FF);
      r_rd(12'h020, v); check("R3 receiver sees status", v, 32'h0000_00FF);
      r_wr(12'h028, 32'h0000_003C);
      r_rd(12'h020, v); check("R3 clear ones", v, 32'h0000_00C3);
      check("R6 masked no irq", {31'b0, rx_irq}, 32'h0);
   endtask

   task automatic t_mask();
      logic [31:0] v;
      r_rd(12'h024, v); check("R4 masked all", v, 32'h0);
      r_wr(12'h038, 32'h0000_0081);
      r_rd(12'h030, v); check("R4 mask clear", v, 32'hFFFF_FF7E);
      r_rd(12'h024, v); check("R4 masked value", v, 32'h0000_0081);
      check("R6 irq on unmasked", {31'b0, rx_irq}, 32'h1);
      r_wr(12'h028, 32'h0000_0081);
      r_rd(12'h024, v); check("R4 masked after clear", v, 32'h0);
      check("R6 irq drops", {31'b0, rx_irq}, 32'h0);
      r_wr(12'h034, 32'h0000_0001);
      r_rd(12'h030, v); check("R4 mask set", v, 32'hFFFF_FF7F);
      r_wr(12'h028, 32'hFFFF_FFFF);
   endtask

   task automatic t_done();
      logic [31:0] v;
      s_wr(12'h058, 32'h1);
      s_wr(12'hF98, 32'h4);
      s_rd(12'hF98, v); check("R8 frame enable readback", v, 32'h4);
      s_wr(12'h04C, 32'h5);
      s_rd(12'h050, v); check("R7 no flag yet", v, 32'h0);
      r_wr(12'h048, 32'h1);
      s_rd(12'h050, v); check("R7 partial drain", v, 32'h0);
      check("R8 no irq partial", {31'b0, tx_done_irq}, 32'h0);
      r_wr(12'h048, 32'h4);
      s_rd(12'h050, v); check("R7 drained flag", v, 32'h1);
      check("R8 tx irq", {31'b0, tx_done_irq}, 32'h1);
      s_rd(12'hFA0, v); check("R9 sender combined", v, 32'h4);
      s_wr(12'h054, 32'h1);
      s_rd(12'h050, v); check("R7 flag cleared", v, 32'h0);
      check("R8 irq cleared", {31'b0, tx_done_irq}, 32'h0);
      s_wr(12'h04C, 32'h1);
      r_wr(12'h048, 32'h1);
      check("R8 irq again", {31'b0, tx_done_irq}, 32'h1);
      s_wr(12'hF98, 32'h0);
      check("R8 frame gate", {31'b0, tx_done_irq}, 32'h0);
      s_rd(12'h050, v); check("R7 flag kept under gate", v, 32'h1);
      s_wr(12'h054, 32'h1);
   endtask

   task automatic t_combined();
      logic [31:0] v;
      r_wr(12'h478, 32'hFFFF_FFFF);
      s_wr(12'h46C, 32'h8000_0000);
      r_rd(12'hFA4, v); check("R9 window 35 at word1 bit3", v, 32'h8);
      r_rd(12'hFA0, v); check("R9 word0 empty", v, 32'h0);
      check("R6 irq window 35", {31'b0, rx_irq}, 32'h1);
      check("R8 rx summary gated", {31'b0, rx_summary_irq}, 32'h0);
      r_wr(12'hF98, 32'h4);
      check("R8 rx summary on", {31'b0, rx_summary_irq}, 32'h1);
      r_wr(12'h468, 32'hFFFF_FFFF);
      r_rd(12'hFA4, v); check("R9 word1 cleared", v, 32'h0);
      check("R8 rx summary off", {31'b0, rx_summary_irq}, 32'h0);
   endtask

   task automatic t_collision();
      logic [31:0] v;
      s_wr(12'h06C, 32'h1);
      both_wr(12'h06C, 32'h1, 12'h068, 32'h1);
      s_rd(12'h060, v); check("R10 set beats clear", v, 32'h1);
      both_wr(12'h06C, 32'h2, 12'h068, 32'h1);
      s_rd(12'h060, v); check("R10 other bit cleared", v, 32'h2);
      s_wr(12'h078, 32'h1);
      both_wr(12'h074, 32'h1, 12'h068, 32'h2);
      s_rd(12'h060, v); check("R10 drained", v, 32'h0);
      s_rd(12'h070, v); check("R7 completion beats clear", v, 32'h1);
      s_wr(12'h074, 32'h1);
      s_rd(12'h070, v); check("R7 later clear", v, 32'h0);
   endtask

   task automatic t_access();
      logic [31:0] v;
      s_wr(12'hF88, 32'h1);
      s_rd(12'hF8C, v); check("R11 ready after request", v, 32'h1);
      s_wr(12'hF88, 32'h0);
      s_rd(12'hF8C, v); check("R11 ready withdrawn", v, 32'h0);
   endtask

   task automatic t_reserved();
      logic [31:0] v;
      s_wr(12'h00C, 32'h0000_000A);
      s_rd(12'h004, v); check("R12 reserved read", v, 32'h0);
      s_rd(12'h00C, v); check("R12 set reads zero", v, 32'h0);
      r_rd(12'h008, v); check("R12 clear reads zero", v, 32'h0);
      s_wr(12'h004, 32'h0000_FFFF);
      s_wr(12'h50C, 32'h1);
      s_rd(12'h000, v); check("R12 status untouched", v, 32'h0000_000A);
      r_rd(12'h500, v); check("R12 absent window", v, 32'h0);
      r_rd(12'hF84, v); check("R12 frame reserved", v, 32'h0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_clear();
      t_mask();
      t_done();
      t_combined();
      t_collision();
      t_access();
      t_reserved();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule